// File: doc/BRIEF.md
# Program Memory Region Access Guard

This block rules on every access to on-chip program memory, one request per clock, and returns a registered verdict one cycle later. An access is one of three kinds: a read by an external programming tool, a write issued by the running firmware, or a table read issued by an instruction. For a table read, the block also takes the address of the instruction that issued it. Program memory is cut into protection regions on power-of-two boundaries. The first region is split unevenly into a small boot region and the rest of that block. The region sizes depend on the selected memory geometry.

Each region has three independent permission bits, all active-low: a read guard, a write guard and a cross-region table-read guard. A cleared bit turns that protection on. The block decodes which region the address falls in, selects the bit that matches the access kind, and reports a single allow flag. When the flag is low on an external read, the read path must return all zeros. The block also reports the region index it decoded.

Top module: `ppc_guard`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rsp_valid` and `rsp_allow` are 0.
- R2: A request sampled on one rising edge gives its verdict at that same edge, so it is visible one cycle later. When `req_valid` was 0, `rsp_valid` and `rsp_allow` are 0.
- R3: With `geo_mode` = 0 (32 KB), bytes 0x0000–0x07FF form the boot region, reported as index 0. Block n spans 8 KB starting at n*8 KB and is reported as index n+1, with block 0 starting at 0x0800. Blocks 0 to 3 exist.
- R4: With `geo_mode` = 1 (64 KB) or 2/3 (128 KB), the boot region is 0x000–0x1FF (index 0) and blocks are 16 KB (index n+1). There are 4 blocks at 64 KB and 8 blocks at 128 KB.
- R5: An address at or above the size of the selected geometry reports region index 15 and is denied.
- R6: An external read (`req_kind` = 0) is allowed only when the target's read bit is 1. That bit is `cp_blk[n]` for block n and `cp_boot` for the boot region.
- R7: A self-write (`req_kind` = 1) is allowed only when the target's write bit is 1. That bit is `wr_blk[n]` for block n and `wr_boot` for the boot region.
- R8: A table read (`req_kind` = 2) is always allowed when the issuing instruction lies in the same region as the target. Otherwise it is allowed only when the target's bit is 1: `tr_blk[n]` for block n, or `tr_boot` for the boot region. An issuing address outside memory counts as a different region.
- R9: Outside the 128 KB geometry, bits 4 to 7 of `cp_blk`, `wr_blk` and `tr_blk` have no effect on any verdict.
- R10: `req_kind` = 3 is reserved and is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 external read, 1 self-write, 2 table read, 3 reserved |
| req_addr | input | ADDR_W | Target byte address |
| exec_addr | input | ADDR_W | Address of the issuing instruction (table reads) |
| geo_mode | input | 2 | 0 = 32 KB, 1 = 64 KB, 2 or 3 = 128 KB |
| cp_blk | input | NBLK | Read guard bits per block, 0 = protected |
| cp_boot | input | 1 | Read guard bit of the boot region |
| wr_blk | input | NBLK | Write guard bits per block, 0 = protected |
| wr_boot | input | 1 | Write guard bit of the boot region |
| tr_blk | input | NBLK | Cross-region table-read bits per block, 0 = protected |
| tr_boot | input | 1 | Cross-region table-read bit of the boot region |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Access permitted |
| rsp_region | output | 4 | Decoded region index, 15 = outside memory |

## Verification
The bench builds the guard with its default parameters. These are a 17-bit byte address, 8 KB blocks with a 2 KB boot region in the small geometry, and 16 KB blocks with a 512-byte boot region in the larger ones. With these values the bench can reach every geometry, including the upper four blocks that exist only at 128 KB, and every boundary between the boot region and block 0. The bench also reaches addresses just past the end of each memory size. This lets it check that the upper guard bits stay inert until the largest geometry is selected.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int NBLK  = 8;
  localparam int IDX_W = 4;

  typedef logic [IDX_W-1:0] region_t;
  localparam region_t REGION_NONE = '1;

  typedef enum logic [1:0] {
    ACC_EXT_READ   = 2'd0,
    ACC_SELF_WRITE = 2'd1,
    ACC_TABLE_READ = 2'd2,
    ACC_RSVD       = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    GEO_32K      = 2'd0,
    GEO_64K      = 2'd1,
    GEO_128K     = 2'd2,
    GEO_128K_ALT = 2'd3
  } geo_e;

  typedef struct packed {
    logic [NBLK:0] rd_ok;
    logic [NBLK:0] wr_ok;
    logic [NBLK:0] tbl_ok;
  } perm_t;
endpackage

// File: rtl/ppc_region_decode.sv
module ppc_region_decode
  import ppc_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int SMALL_BLK_LG  = 13,
  parameter int SMALL_BOOT_LG = 11,
  parameter int LARGE_BLK_LG  = 14,
  parameter int LARGE_BOOT_LG = 9,
  parameter int NARROW_BLKS   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  geo_e              geo,
  output region_t           region
);
  localparam int NARROW_LG  = $clog2(NARROW_BLKS);
  localparam int WIDE_LG    = $clog2(NBLK);
  localparam int SMALL_SPAN = SMALL_BLK_LG + NARROW_LG;
  localparam int MID_SPAN   = LARGE_BLK_LG + NARROW_LG;
  localparam int FULL_SPAN  = LARGE_BLK_LG + WIDE_LG;

  int      blk_lg;
  int      boot_lg;
  int      span_lg;
  logic    in_range;
  logic    in_boot;
  region_t blk_num;

  always_comb begin
    unique case (geo)
      GEO_32K: begin
        blk_lg  = SMALL_BLK_LG;
        boot_lg = SMALL_BOOT_LG;
        span_lg = SMALL_SPAN;
      end
      GEO_64K: begin
        blk_lg  = LARGE_BLK_LG;
        boot_lg = LARGE_BOOT_LG;
        span_lg = MID_SPAN;
      end
      default: begin
        blk_lg  = LARGE_BLK_LG;
        boot_lg = LARGE_BOOT_LG;
        span_lg = FULL_SPAN;
      end
    endcase
    blk_num  = region_t'(addr >> blk_lg);
    in_range = (span_lg >= ADDR_W) || ((addr >> span_lg) == '0);
    in_boot  = (addr >> boot_lg) == '0;
    if (!in_range)    region = REGION_NONE;
    else if (in_boot) region = '0;
    else              region = blk_num + region_t'(1);
  end
endmodule

// File: rtl/ppc_perm_map.sv
module ppc_perm_map
  import ppc_pkg::*;
#(
  parameter int NARROW_BLKS = 4
) (
  input  geo_e            geo,
  input  logic [NBLK-1:0] cp_blk,
  input  logic            cp_boot,
  input  logic [NBLK-1:0] wr_blk,
  input  logic            wr_boot,
  input  logic [NBLK-1:0] tr_blk,
  input  logic            tr_boot,
  output perm_t           perm
);
  logic wide_geo;
  assign wide_geo = (geo == GEO_128K) || (geo == GEO_128K_ALT);

  assign perm.rd_ok[0]  = cp_boot;
  assign perm.wr_ok[0]  = wr_boot;
  assign perm.tbl_ok[0] = tr_boot;

  for (genvar n = 0; n < NBLK; n++) begin : g_blk
    if (n < NARROW_BLKS) begin : g_base
      assign perm.rd_ok[n+1]  = cp_blk[n];
      assign perm.wr_ok[n+1]  = wr_blk[n];
      assign perm.tbl_ok[n+1] = tr_blk[n];
    end else begin : g_upper
      // absent in the narrow geometries: read as unprotected
      assign perm.rd_ok[n+1]  = cp_blk[n] | ~wide_geo;
      assign perm.wr_ok[n+1]  = wr_blk[n] | ~wide_geo;
      assign perm.tbl_ok[n+1] = tr_blk[n] | ~wide_geo;
    end
  end
endmodule

// File: rtl/ppc_rule_eval.sv
module ppc_rule_eval
  import ppc_pkg::*;
(
  input  acc_kind_e kind,
  input  region_t   tgt,
  input  region_t   src,
  input  perm_t     perm,
  output logic      allow
);
  logic in_map;
  assign in_map = (tgt != REGION_NONE) && (tgt <= region_t'(NBLK));

  always_comb begin
    allow = 1'b0;
    if (in_map) begin
      unique case (kind)
        ACC_EXT_READ:   allow = perm.rd_ok[tgt];
        ACC_SELF_WRITE: allow = perm.wr_ok[tgt];
        ACC_TABLE_READ: allow = (src == tgt) || perm.tbl_ok[tgt];
        default:        allow = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ppc_guard.sv
module ppc_guard
  import ppc_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int SMALL_BLK_LG  = 13,
  parameter int SMALL_BOOT_LG = 11,
  parameter int LARGE_BLK_LG  = 14,
  parameter int LARGE_BOOT_LG = 9,
  parameter int NARROW_BLKS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic [1:0]        geo_mode,
  input  logic [NBLK-1:0]   cp_blk,
  input  logic              cp_boot,
  input  logic [NBLK-1:0]   wr_blk,
  input  logic              wr_boot,
  input  logic [NBLK-1:0]   tr_blk,
  input  logic              tr_boot,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic [IDX_W-1:0]  rsp_region
);
  geo_e    geo;
  region_t reg_of [2];
  perm_t   perm;
  logic    allow_c;

  assign geo = geo_e'(geo_mode);

  // port 0 decodes the target, port 1 the issuing instruction
  for (genvar p = 0; p < 2; p++) begin : g_dec
    ppc_region_decode #(
      .ADDR_W(ADDR_W), .SMALL_BLK_LG(SMALL_BLK_LG), .SMALL_BOOT_LG(SMALL_BOOT_LG),
      .LARGE_BLK_LG(LARGE_BLK_LG), .LARGE_BOOT_LG(LARGE_BOOT_LG),
      .NARROW_BLKS(NARROW_BLKS)
    ) dec_i (
      .addr  (p == 0 ? req_addr : exec_addr),
      .geo   (geo),
      .region(reg_of[p])
    );
  end

  ppc_perm_map #(.NARROW_BLKS(NARROW_BLKS)) map_i (
    .geo(geo), .cp_blk(cp_blk), .cp_boot(cp_boot), .wr_blk(wr_blk),
    .wr_boot(wr_boot), .tr_blk(tr_blk), .tr_boot(tr_boot), .perm(perm)
  );

  ppc_rule_eval eval_i (
    .kind (acc_kind_e'(req_kind)),
    .tgt  (reg_of[0]),
    .src  (reg_of[1]),
    .perm (perm),
    .allow(allow_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_region <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_allow  <= req_valid & allow_c;
      rsp_region <= req_valid ? reg_of[0] : '0;
    end
  end
endmodule

// File: rtl/ppc_guard_chk.sv
module ppc_guard_chk
  import ppc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [1:0]       geo_mode,
  input logic [NBLK-1:0]  cp_blk,
  input logic             cp_boot,
  input logic [NBLK-1:0]  wr_blk,
  input logic             wr_boot,
  input logic [NBLK-1:0]  tr_blk,
  input logic             tr_boot,
  input logic             rsp_valid,
  input logic             rsp_allow,
  input logic [IDX_W-1:0] rsp_region
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rsp_valid && !rsp_allow));
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_allow));
  // R3
  small_span_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(geo_mode) == 2'd0) |-> (rsp_region <= 4'd4 || rsp_region == 4'hF));
  // R4
  mid_span_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(geo_mode) == 2'd1) |-> (rsp_region <= 4'd4 || rsp_region == 4'hF));
  // R4
  full_span_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(geo_mode) >= 2'd2) |-> (rsp_region <= 4'd8 || rsp_region == 4'hF));
  // R5
  outside_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_region == 4'hF) |-> !rsp_allow);
  // R6 R7 R8
  open_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != 2'd3 && (&cp_blk) && cp_boot && (&wr_blk) && wr_boot
     && (&tr_blk) && tr_boot) |=> (rsp_allow || rsp_region == 4'hF));
  // R10
  rsvd_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd3) |=> !rsp_allow);
endmodule

bind ppc_guard ppc_guard_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .geo_mode(geo_mode), .cp_blk(cp_blk), .cp_boot(cp_boot), .wr_blk(wr_blk),
  .wr_boot(wr_boot), .tr_blk(tr_blk), .tr_boot(tr_boot), .rsp_valid(rsp_valid),
  .rsp_allow(rsp_allow), .rsp_region(rsp_region)
);

// File: tb/ppc_guard_tb_top.sv
`timescale 1ns/1ps
module ppc_guard_tb_top;
  localparam int AW = 17;
  // {geo[2], kind[2], addr[17], exec[17], allow, region[4]}
  localparam int VW = 43;
  localparam int NV = 22;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 2'd0, 17'h00100, 17'h00000, 1'b0, 4'd0},  // R3 R6 boot read guarded
    {2'd0, 2'd0, 17'h00800, 17'h00000, 1'b1, 4'd1},  // R3 R6 block0 start
    {2'd0, 2'd0, 17'h02000, 17'h00000, 1'b0, 4'd2},  // R6 block1 guarded
    {2'd0, 2'd1, 17'h07FFF, 17'h00000, 1'b1, 4'd4},  // R7 block3 top byte
    {2'd0, 2'd1, 17'h04000, 17'h00000, 1'b0, 4'd3},  // R7 block2 guarded
    {2'd0, 2'd0, 17'h08000, 17'h00000, 1'b0, 4'hF},  // R5 past 32K
    {2'd1, 2'd0, 17'h001FF, 17'h00000, 1'b0, 4'd0},  // R4 boot last byte
    {2'd1, 2'd0, 17'h00200, 17'h00000, 1'b1, 4'd1},  // R4 block0 start
    {2'd1, 2'd1, 17'h00200, 17'h00000, 1'b0, 4'd1},  // R7 block0 guarded
    {2'd1, 2'd2, 17'h00300, 17'h03000, 1'b1, 4'd1},  // R8 same region
    {2'd1, 2'd2, 17'h00300, 17'h04000, 1'b0, 4'd1},  // R8 cross, guarded
    {2'd1, 2'd2, 17'h04000, 17'h00000, 1'b1, 4'd2},  // R8 cross, open
    {2'd1, 2'd0, 17'h10000, 17'h00000, 1'b0, 4'hF},  // R5 past 64K
    {2'd2, 2'd0, 17'h1C000, 17'h00000, 1'b1, 4'd8},  // R4 block7
    {2'd2, 2'd2, 17'h1FFFF, 17'h00000, 1'b0, 4'd8},  // R8 block7 cross guarded
    {2'd2, 2'd2, 17'h1C004, 17'h1D000, 1'b1, 4'd8},  // R8 block7 same
    {2'd2, 2'd2, 17'h00010, 17'h00100, 1'b1, 4'd0},  // R8 boot same
    {2'd2, 2'd2, 17'h00010, 17'h00800, 1'b0, 4'd0},  // R8 boot cross guarded
    {2'd2, 2'd3, 17'h00800, 17'h00000, 1'b0, 4'd1},  // R10 reserved kind
    {2'd0, 2'd2, 17'h00700, 17'h00900, 1'b0, 4'd0},  // R8 R3 boot vs block0
    {2'd3, 2'd1, 17'h0C000, 17'h00000, 1'b1, 4'd4},  // R4 R7 alt 128K code
    {2'd0, 2'd2, 17'h00900, 17'h09000, 1'b0, 4'd1}   // R8 issuer outside
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic [AW-1:0] exec_addr = '0;
  logic [1:0]    geo_mode = '0;
  logic [7:0]    cp_blk = 8'hF5;
  logic          cp_boot = 1'b0;
  logic [7:0]    wr_blk = 8'hFA;
  logic          wr_boot = 1'b1;
  logic [7:0]    tr_blk = 8'h7E;
  logic          tr_boot = 1'b0;
  logic          rsp_valid;
  logic          rsp_allow;
  logic [3:0]    rsp_region;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  ppc_guard dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .exec_addr(exec_addr), .geo_mode(geo_mode),
    .cp_blk(cp_blk), .cp_boot(cp_boot), .wr_blk(wr_blk), .wr_boot(wr_boot),
    .tr_blk(tr_blk), .tr_boot(tr_boot), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_region(rsp_region)
  );

  task automatic expect_rsp(input string tag, input logic v, input logic a, input logic [3:0] r);
    checks++;
    if ({rsp_valid, rsp_allow, rsp_region} !== {v, a, r}) begin
      errors++;
      $display("FAIL %s: valid/allow/region got %b/%b/%0d expected %b/%b/%0d",
               tag, rsp_valid, rsp_allow, rsp_region, v, a, r);
    end
  endtask

  task automatic issue(input logic [1:0] g, input logic [1:0] k,
                       input logic [AW-1:0] ad, input logic [AW-1:0] ex);
    @(negedge clk);
    geo_mode = g; req_kind = k; req_addr = ad; exec_addr = ex; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_rsp("R1 in reset", 1'b0, 1'b0, 4'd0);
    rst = 1'b0;
    @(negedge clk);
    expect_rsp("R1 after release", 1'b0, 1'b0, 4'd0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      issue(v[42:41], v[40:39], v[38:22], v[21:5]);
      expect_rsp($sformatf("R3/R4/R5/R6/R7/R8/R10 vector %0d", i), 1'b1, v[4], v[3:0]);
    end

    // R2: idle cycle yields no verdict
    @(negedge clk);
    expect_rsp("R2 idle", 1'b0, 1'b0, 4'd0);

    // R9: upper bits cleared, narrow geometries unaffected
    cp_blk = 8'h0F; cp_boot = 1'b1;
    issue(2'd0, 2'd0, 17'h06000, 17'h0);
    expect_rsp("R9 32K block3 read", 1'b1, 1'b1, 4'd4);
    wr_blk = 8'h0F;
    issue(2'd1, 2'd1, 17'h0C000, 17'h0);
    expect_rsp("R9 64K block3 write", 1'b1, 1'b1, 4'd4);
    tr_blk = 8'h0F;
    issue(2'd1, 2'd2, 17'h00200, 17'h08000);
    expect_rsp("R9 64K block0 table", 1'b1, 1'b1, 4'd1);
    issue(2'd2, 2'd0, 17'h10000, 17'h0);
    expect_rsp("R9 R6 128K block4 now guarded", 1'b1, 1'b0, 4'd5);

    // R1: reset during a request
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b1; req_kind = 2'd0; req_addr = 17'h00800; geo_mode = 2'd0;
    @(negedge clk);
    expect_rsp("R1 reset overrides request", 1'b0, 1'b0, 4'd0);
    rst = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    expect_rsp("R1 R2 after second reset", 1'b0, 1'b0, 4'd0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule